// File: doc/BRIEF.md
# Registered Command Buffer with Parity Check

This block sits between a memory controller and a rank of memory devices and re-times the address, bank, command and control signals by one clock, in the way the register on a registered memory module does. Chip selects, clock enables and on-die termination controls are always passed through the register. The address, bank and command strobes are only updated on cycles where at least one chip select is asserted (low). When both chip selects are high, those outputs keep their last values so the shared bus toward the devices does not toggle.

In the same cycle as it registers a command, the block checks the even/odd parity bit that the controller sends with it. On a mismatch it pulls a shared, open-drain error line low for a fixed number of cycles. The line is modelled as an enable: when the enable is high the pad drives 0, and when it is low the pad is released to its external pull-up.

Top module: `cmd_regbuf`

## Requirements
- R1: While `rst_n` is low, every registered output (`cs_n_q`, `cke_q`, `odt_q`, `addr_q`, `ba_q`, `ras_n_q`, `cas_n_q`, `we_n_q`) is 0 and `err_drv_o` is 0 (line released).
- R2: When at least one bit of `cs_n_i` is 0 at a rising clock edge, `addr_q`, `ba_q`, `ras_n_q`, `cas_n_q` and `we_n_q` show the input values sampled at that edge, one clock after the inputs.
- R3: When all bits of `cs_n_i` are 1 at a rising edge, `addr_q`, `ba_q`, `ras_n_q`, `cas_n_q` and `we_n_q` keep their previous values.
- R4: `cs_n_q`, `cke_q` and `odt_q` always take the values sampled at the previous rising edge, whatever the chip select state.
- R5: The parity input `par_i` is correct when it equals the XOR of `addr_i[15:0]`, `ba_i[2:0]`, `ras_n_i`, `cas_n_i` and `we_n_i` as driven (1 means an odd count of ones). A correct parity never raises `err_drv_o`.
- R6: A parity mismatch sampled at an edge with at least one chip select low sets `err_drv_o` to 1 starting right after that edge.
- R7: After the last mismatch, `err_drv_o` stays 1 for exactly `ERR_HOLD` (default 2) clock cycles and then returns to 0; a new mismatch within that window restarts the count.
- R8: Parity is not checked when all chip selects are high: a wrong `par_i` on such a cycle leaves `err_drv_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | NCS (2) | Chip selects, active low |
| cke_i | input | NCKE (2) | Clock enables |
| odt_i | input | NODT (2) | On-die termination controls |
| addr_i | input | AW (16) | Address bits |
| ba_i | input | BW (3) | Bank address |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| par_i | input | 1 | Parity over address, bank and command bits |
| cs_n_q | output | NCS | Registered chip selects |
| cke_q | output | NCKE | Registered clock enables |
| odt_q | output | NODT | Registered termination controls |
| addr_q | output | AW | Registered address (held when deselected) |
| ba_q | output | BW | Registered bank (held when deselected) |
| ras_n_q | output | 1 | Registered row strobe (held when deselected) |
| cas_n_q | output | 1 | Registered column strobe (held when deselected) |
| we_n_q | output | 1 | Registered write enable (held when deselected) |
| err_drv_o | output | 1 | Open-drain enable: 1 pulls the error line low |

## Verification
The bench builds the block with its default parameters: two chip selects, a 16-bit address, a 3-bit bank and an error hold of two cycles. The short hold lets the bench see the full rise, hold and release of the error line, as well as a restart by a second mismatch, within a few cycles. The two chip selects allow a one-low, a both-low and a both-high case, which separates the hold behaviour from the pass-through behaviour.

// File: rtl/cmdreg_pkg.sv
package cmdreg_pkg;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam int CMD_W = 3;

  function automatic logic cmd_par(input cmd_t c);
    return c.ras_n ^ c.cas_n ^ c.we_n;
  endfunction

  // Next error hold count given the current count and a fresh mismatch.
  function automatic int unsigned hold_next(input int unsigned cur,
                                            input logic fresh,
                                            input int unsigned hold);
    if (fresh) return hold;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

endpackage

// File: rtl/cmdreg_flop.sv
module cmdreg_flop #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/cmdreg_parity.sv
module cmdreg_parity
  import cmdreg_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BW       = 3,
  parameter int NCS      = 2,
  parameter int ERR_HOLD = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCS-1:0] cs_n_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [BW-1:0]  ba_i,
  input  cmd_t           cmd_i,
  input  logic           par_i,
  output logic           chk_en,
  output logic           mismatch,
  output logic           err_drv
);
  localparam int CW = $clog2(ERR_HOLD + 1);

  logic          calc;
  logic [CW-1:0] cnt;

  assign chk_en   = ~&cs_n_i;
  assign calc     = (^addr_i) ^ (^ba_i) ^ cmd_par(cmd_i);
  assign mismatch = chk_en & (calc != par_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= CW'(hold_next(int'(cnt), mismatch, ERR_HOLD));
  end

  assign err_drv = (cnt != '0);
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmdreg_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BW       = 3,
  parameter int NCS      = 2,
  parameter int NCKE     = 2,
  parameter int NODT     = 2,
  parameter int ERR_HOLD = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCS-1:0]  cs_n_i,
  input  logic [NCKE-1:0] cke_i,
  input  logic [NODT-1:0] odt_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   ba_i,
  input  logic            ras_n_i,
  input  logic            cas_n_i,
  input  logic            we_n_i,
  input  logic            par_i,
  output logic [NCS-1:0]  cs_n_q,
  output logic [NCKE-1:0] cke_q,
  output logic [NODT-1:0] odt_q,
  output logic [AW-1:0]   addr_q,
  output logic [BW-1:0]   ba_q,
  output logic            ras_n_q,
  output logic            cas_n_q,
  output logic            we_n_q,
  output logic            err_drv_o
);
  localparam int CTRL_W = NCS + NCKE + NODT;
  localparam int BUS_W  = AW + BW + CMD_W;

  cmd_t              cmd_in, cmd_out;
  logic              chk_en, mismatch;
  logic [CTRL_W-1:0] ctrl_d, ctrl_q;
  logic [BUS_W-1:0]  bus_d, bus_q;

  assign cmd_in = '{ras_n: ras_n_i, cas_n: cas_n_i, we_n: we_n_i};
  assign ctrl_d = {cs_n_i, cke_i, odt_i};
  assign bus_d  = {addr_i, ba_i, cmd_in};

  // Control path: always registered.
  cmdreg_flop #(.W(CTRL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en(1'b1), .d(ctrl_d), .q(ctrl_q)
  );

  // Address/command path: updated only while some chip select is low.
  cmdreg_flop #(.W(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .en(chk_en), .d(bus_d), .q(bus_q)
  );

  cmdreg_parity #(.AW(AW), .BW(BW), .NCS(NCS), .ERR_HOLD(ERR_HOLD)) u_par (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .addr_i(addr_i), .ba_i(ba_i),
    .cmd_i(cmd_in), .par_i(par_i), .chk_en(chk_en), .mismatch(mismatch),
    .err_drv(err_drv_o)
  );

  assign {cs_n_q, cke_q, odt_q}  = ctrl_q;
  assign {addr_q, ba_q, cmd_out} = bus_q;
  assign ras_n_q = cmd_out.ras_n;
  assign cas_n_q = cmd_out.cas_n;
  assign we_n_q  = cmd_out.we_n;
endmodule

// File: rtl/cmdreg_chk.sv
module cmdreg_chk #(
  parameter int AW       = 16,
  parameter int BW       = 3,
  parameter int NCS      = 2,
  parameter int NCKE     = 2,
  parameter int NODT     = 2,
  parameter int ERR_HOLD = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NCS-1:0]  cs_n_i,
  input logic [NCKE-1:0] cke_i,
  input logic [NODT-1:0] odt_i,
  input logic [AW-1:0]   addr_i,
  input logic [NCS-1:0]  cs_n_q,
  input logic [NCKE-1:0] cke_q,
  input logic [NODT-1:0] odt_q,
  input logic [AW-1:0]   addr_q,
  input logic [BW-1:0]   ba_q,
  input logic            ras_n_q,
  input logic            chk_en,
  input logic            mismatch,
  input logic            err_drv_o
);
  localparam int CW = $clog2(ERR_HOLD + 1);
  logic [CW-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run <= '0;
    else if (mismatch) run <= CW'(ERR_HOLD);
    else if (run != 0) run <= run - 1'b1;
  end

  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |-> (cs_n_q == '0 && cke_q == '0 && odt_q == '0 && addr_q == '0 &&
                ba_q == '0 && !ras_n_q && !err_drv_o));

  a_r2_addr_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (~&cs_n_i) |=> addr_q == $past(addr_i));

  a_r3_hold_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (&cs_n_i) |=> ($stable(addr_q) && $stable(ba_q) && $stable(ras_n_q)));

  a_r4_ctrl_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cke_q == $past(cke_i) && odt_q == $past(odt_i) &&
              cs_n_q == $past(cs_n_i)));

  a_r6_err_rise: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> err_drv_o);

  a_r7_err_window: assert property (@(posedge clk) disable iff (!rst_n)
    err_drv_o == (run != '0));

  a_r8_no_check_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> !mismatch);
endmodule

bind cmd_regbuf cmdreg_chk #(
  .AW(AW), .BW(BW), .NCS(NCS), .NCKE(NCKE), .NODT(NODT), .ERR_HOLD(ERR_HOLD)
) u_cmdreg_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .cke_i(cke_i), .odt_i(odt_i),
  .addr_i(addr_i), .cs_n_q(cs_n_q), .cke_q(cke_q), .odt_q(odt_q),
  .addr_q(addr_q), .ba_q(ba_q), .ras_n_q(ras_n_q), .chk_en(chk_en),
  .mismatch(mismatch), .err_drv_o(err_drv_o)
);

// File: tb/test_cmd_regbuf.sv
module test_cmd_regbuf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cs_n = 2'b11, cke = '0, odt = '0;
  logic [15:0] addr = '0;
  logic [2:0]  ba = '0;
  logic        ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, par = 1'b0;
  logic [1:0]  cs_n_q, cke_q, odt_q;
  logic [15:0] addr_q;
  logic [2:0]  ba_q;
  logic        ras_n_q, cas_n_q, we_n_q, err;

  int checks = 0;
  int errors = 0;
  bit timed_out = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_regbuf i_cmd_regbuf (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cke_i(cke), .odt_i(odt),
    .addr_i(addr), .ba_i(ba), .ras_n_i(ras_n), .cas_n_i(cas_n), .we_n_i(we_n),
    .par_i(par), .cs_n_q(cs_n_q), .cke_q(cke_q), .odt_q(odt_q), .addr_q(addr_q),
    .ba_q(ba_q), .ras_n_q(ras_n_q), .cas_n_q(cas_n_q), .we_n_q(we_n_q),
    .err_drv_o(err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Odd-count rule counted bit by bit.
  function automatic logic ref_par(input logic [15:0] a, input logic [2:0] b,
                                   input logic r, input logic c, input logic w);
    int n = 0;
    for (int i = 0; i < 16; i++) n += a[i];
    for (int i = 0; i < 3; i++) n += b[i];
    n += r + c + w;
    return (n % 2) == 1;
  endfunction

  task automatic drive(input logic [1:0] cs, input logic [15:0] a, input logic [2:0] b,
                       input logic [2:0] cmd, input bit good);
    cs_n = cs; addr = a; ba = b; {ras_n, cas_n, we_n} = cmd;
    par = ref_par(a, b, cmd[2], cmd[1], cmd[0]) ^ !good;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    drive(2'b00, 16'hFFFF, 3'h7, 3'b111, 0);
    cke = 2'b11; odt = 2'b11;
    step();
    check("R1 addr", addr_q, 0);
    check("R1 ctrl", {cs_n_q, cke_q, odt_q}, 0);
    check("R1 cmd", {ba_q, ras_n_q, cas_n_q, we_n_q}, 0);
    check("R1 err", err, 0);
    rst_n = 1'b1;
    drive(2'b11, 16'h0, 3'h0, 3'b111, 1);
    step();
  endtask

  task automatic t_pass();
    drive(2'b10, 16'hA5C3, 3'h5, 3'b010, 1);
    step();
    check("R2 addr", addr_q, 16'hA5C3);
    check("R2 ba/cmd", {ba_q, ras_n_q, cas_n_q, we_n_q}, {3'h5, 3'b010});
    check("R5 good parity no err", err, 0);
  endtask

  task automatic t_hold();
    drive(2'b11, 16'h1234, 3'h2, 3'b101, 1);
    cke = 2'b01; odt = 2'b10;
    step();
    check("R3 addr held", addr_q, 16'hA5C3);
    check("R3 ba/cmd held", {ba_q, ras_n_q, cas_n_q, we_n_q}, {3'h5, 3'b010});
    check("R4 ctrl follow while deselected", {cs_n_q, cke_q, odt_q}, {2'b11, 2'b01, 2'b10});
    cke = 2'b10; odt = 2'b01;
    step();
    check("R4 ctrl follow again", {cke_q, odt_q}, {2'b10, 2'b01});
    check("R3 addr still held", addr_q, 16'hA5C3);
  endtask

  task automatic t_patterns();
    logic [15:0] pats [4] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h8421};
    for (int k = 0; k < 4; k++) begin
      drive(k[0] ? 2'b01 : 2'b00, pats[k], 3'(k), 3'(k + 3), 1);
      step();
      check("R2 pattern addr", addr_q, pats[k]);
      check("R5 pattern no err", err, 0);
    end
  endtask

  task automatic t_bad();
    drive(2'b01, 16'h00F0, 3'h1, 3'b011, 0);
    step();
    check("R6 err set", err, 1);
    drive(2'b11, 16'h0, 3'h0, 3'b111, 1);
    step();
    check("R7 err second cycle", err, 1);
    step();
    check("R7 err released", err, 0);
  endtask

  task automatic t_ignore();
    drive(2'b11, 16'h7777, 3'h3, 3'b000, 0);
    step();
    check("R8 no check deselected", err, 0);
    step();
    check("R8 still released", err, 0);
  endtask

  task automatic t_extend();
    drive(2'b00, 16'h0101, 3'h4, 3'b110, 0);
    step();
    check("R6 err set again", err, 1);
    drive(2'b00, 16'h0202, 3'h4, 3'b110, 1);
    step();
    check("R7 err hold", err, 1);
    drive(2'b00, 16'h0303, 3'h4, 3'b110, 0);
    step();
    check("R7 restart", err, 1);
    drive(2'b00, 16'h0404, 3'h4, 3'b110, 1);
    step();
    check("R7 restart hold", err, 1);
    step();
    check("R7 restart released", err, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pass();
        t_hold();
        t_patterns();
        t_bad();
        t_ignore();
        t_extend();
      end
      begin
        repeat (5000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule